// File: doc/BRIEF.md
# Pushbutton Saturating Decimal Counter

This block keeps a two-digit decimal value from 00 to 99 that two pushbuttons move, one counting up and one counting down. Both buttons are active low. They are read only when a sampling strobe is high (in a system this is a slow tick, around every 8 ms, which also rides over contact bounce). A two-bit memory holds the levels seen at the previous strobe. The block acts on a button only in the strobe where that button is first seen pressed. Holding a button or letting it go does nothing.

Each new press moves the value by one step. It stops at the ends of the range instead of wrapping round. On the same clock edge the value is also given as a tens digit and a ones digit, ready for a display driver. The digits come from four fixed trial subtractions of 80, 40, 20 and 10, each kept only if it does not borrow. The binary value and both digits are registered and do not change between strobes.

Top module: `pb_decimal_counter`

## Requirements
- R1: The button inputs are active low: a 0 on `up_btn_n` or `dn_btn_n` is read as pressed, and a 1 as released.
- R2: At each strobe the block compares the pressed state of each button with the state it stored at the previous strobe, then stores the new state. A new press is a button that changed and is now pressed. Button activity between strobes is never stored.
- R3: A button that is held across strobes, or that is released, leaves the count unchanged.
- R4: If the down button has a new press in a strobe, the count goes down by one, even when the up button also has a new press in that strobe. A new up press alone makes the count go up by one.
- R5: A new up press at 99 leaves the count at 99. A new down press at 0 leaves it at 0. The count is never above 99.
- R6: `tens_o` equals the count divided by 10 and `ones_o` equals the count modulo 10. Both are plain binary in 4 bits.
- R7: The count changes by at most one per strobe. When `tick` is low the count and both digits keep their values.
- R8: A high `rst` at a clock edge clears the count, both digits and the stored button state to zero (both released).
- R9: `count_o`, `tens_o` and `ones_o` take their new values on the same clock edge, the edge at which `tick` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sampling strobe, one clock wide |
| up_btn_n | input | 1 | Up button, 0 = pressed |
| dn_btn_n | input | 1 | Down button, 0 = pressed |
| count_o | output | 7 | Binary count, 0 to 99 |
| tens_o | output | 4 | Tens digit |
| ones_o | output | 4 | Ones digit |

## Verification
All three outputs are due one clock edge after the edge that samples `tick` high. Before that edge they must still show the previous result. The driver puts the buttons and `tick` on a falling edge and queues the expected value it works out for that strobe. The monitor notes a strobe at the rising edge and compares the outputs on the falling edge that follows. The gaps between strobes and the reset are checked directly on falling edges, so that each sample falls half a cycle after the register it observes has settled.

// File: rtl/pb_pkg.sv
package pb_pkg;
  // pressed-level pair, 1 = pressed
  typedef struct packed {
    logic dn;
    logic up;
  } btn_pair_t;

  localparam int DEC_BASE = 10;
endpackage

// File: rtl/pb_press_detect.sv
module pb_press_detect
  import pb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      up_btn_n,
  input  logic      dn_btn_n,
  output btn_pair_t fresh_o
);
  btn_pair_t level_now;
  btn_pair_t level_q;
  btn_pair_t toggled;

  always_comb begin
    level_now.up = ~up_btn_n;
    level_now.dn = ~dn_btn_n;
    toggled      = level_now ^ level_q;
    fresh_o      = tick ? (toggled & level_now) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       level_q <= '0;
    else if (tick) level_q <= level_now;
  end

  // R2: stored state follows the strobe sample
  assert_latch_follows_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> level_q == {~$past(dn_btn_n), ~$past(up_btn_n)});
  // R2: no storage outside strobes
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level_q));
endmodule

// File: rtl/pb_sat_counter.sv
module pb_sat_counter
  import pb_pkg::*;
#(
  parameter int MAX_COUNT = 99,
  parameter int COUNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  btn_pair_t          fresh_i,
  output logic [COUNT_W-1:0] count_next_o,
  output logic [COUNT_W-1:0] count_o
);
  localparam logic [COUNT_W-1:0] TOP = COUNT_W'(MAX_COUNT);

  logic [COUNT_W-1:0] count_q;

  always_comb begin
    count_next_o = count_q;
    if (fresh_i.dn) begin
      if (count_q != '0) count_next_o = count_q - 1'b1;
    end else if (fresh_i.up) begin
      if (count_q != TOP) count_next_o = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_next_o;
  end

  assign count_o = count_q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    count_q <= TOP);
  assert_down_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (fresh_i.dn && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  assert_quiet_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/pb_bcd_split.sv
module pb_bcd_split
  import pb_pkg::*;
#(
  parameter int COUNT_W = 7,
  parameter int DIGIT_W = 4
) (
  input  logic [COUNT_W-1:0] value_i,
  output logic [DIGIT_W-1:0] tens_o,
  output logic [DIGIT_W-1:0] ones_o
);
  localparam int STEPS = DIGIT_W;
  localparam int RW    = COUNT_W + 1;

  logic [RW-1:0] rem [STEPS+1];

  assign rem[0] = RW'(value_i);

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    localparam int WT = DEC_BASE << (STEPS - 1 - k);
    localparam logic [RW:0] WTV = (RW+1)'(WT);
    logic [RW:0] diff;
    assign diff = {1'b0, rem[k]} - WTV;
    assign tens_o[STEPS-1-k] = ~diff[RW];
    assign rem[k+1] = diff[RW] ? rem[k] : diff[RW-1:0];
  end

  assign ones_o = rem[STEPS][DIGIT_W-1:0];

  // R6: remainder after the last step is a single decimal digit
  always_comb begin
    if (value_i < COUNT_W'(DEC_BASE * DEC_BASE))
      assert_ones_range_R6: assert (rem[STEPS] < RW'(DEC_BASE));
  end
endmodule

// File: rtl/pb_decimal_counter.sv
module pb_decimal_counter
  import pb_pkg::*;
#(
  parameter int MAX_COUNT = 99,
  parameter int DIGIT_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         up_btn_n,
  input  logic                         dn_btn_n,
  output logic [$clog2(MAX_COUNT+1)-1:0] count_o,
  output logic [DIGIT_W-1:0]           tens_o,
  output logic [DIGIT_W-1:0]           ones_o
);
  localparam int COUNT_W = $clog2(MAX_COUNT + 1);

  btn_pair_t          fresh;
  logic [COUNT_W-1:0] count_next;
  logic [DIGIT_W-1:0] tens_next, ones_next;

  pb_press_detect u_press (
    .clk, .rst, .tick, .up_btn_n, .dn_btn_n, .fresh_o(fresh)
  );

  pb_sat_counter #(.MAX_COUNT(MAX_COUNT), .COUNT_W(COUNT_W)) u_count (
    .clk, .rst, .tick, .fresh_i(fresh),
    .count_next_o(count_next), .count_o(count_o)
  );

  pb_bcd_split #(.COUNT_W(COUNT_W), .DIGIT_W(DIGIT_W)) u_split (
    .value_i(count_next), .tens_o(tens_next), .ones_o(ones_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tens_o <= '0;
      ones_o <= '0;
    end else if (tick) begin
      tens_o <= tens_next;
      ones_o <= ones_next;
    end
  end

  // R6, R9: registered digits always match the registered count
  assert_digits_match_R9: assert property (@(posedge clk) disable iff (rst)
    int'(tens_o) * DEC_BASE + int'(ones_o) == int'(count_o));
  assert_ones_digit_R6: assert property (@(posedge clk) disable iff (rst)
    int'(ones_o) < DEC_BASE);
endmodule

// File: tb/pb_decimal_counter_test.sv
module pb_decimal_counter_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       tick = 0;
  logic       up_btn_n = 1;
  logic       dn_btn_n = 1;
  logic [6:0] count_o;
  logic [3:0] tens_o, ones_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  logic ticked = 0;
  bit m_up = 0, m_dn = 0;
  int m_cnt = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pb_decimal_counter uut (
    .clk, .rst, .tick, .up_btn_n, .dn_btn_n, .count_o, .tens_o, .ones_o
  );

  always @(posedge clk) begin
    ticked <= tick && !rst;
    cycles <= cycles + 1;
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic chk_out(string tag, int expv);
    chk(count_o == expv, {tag, " count"}, count_o, expv);
    chk(tens_o == expv / 10, {tag, " tens"}, tens_o, expv / 10);
    chk(ones_o == expv % 10, {tag, " ones"}, ones_o, expv % 10);
  endtask

  // monitor: compare on the falling edge after a sampled strobe
  always @(negedge clk) begin
    if (ticked) begin
      if (exp_q.size() == 0) chk(0, "queue underflow", 0, 1);
      else chk_out(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  // driver: one strobe with the given pressed levels; queues expected value
  task automatic strobe(bit up, bit dn, string tag);
    bit nu, nd;
    @(negedge clk);
    up_btn_n = ~up;
    dn_btn_n = ~dn;
    tick = 1;
    nu = up && !m_up;
    nd = dn && !m_dn;
    m_up = up;
    m_dn = dn;
    if (nd) m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
    else if (nu) m_cnt = (m_cnt == 99) ? 99 : m_cnt + 1;
    exp_q.push_back(m_cnt);
    tag_q.push_back(tag);
    @(negedge clk);
    tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_up = 0;
    m_dn = 0;
    m_cnt = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cycles == 20000);
    chk(0, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_out("R8 reset", 0);

    strobe(0, 0, "R3 idle");
    strobe(1, 0, "R1 up press");
    strobe(1, 0, "R3 held");
    strobe(0, 0, "R3 release");
    // climb to the top through press/release pairs
    for (int i = 0; i < 100; i++) begin
      strobe(1, 0, "R6 climb");
      strobe(0, 0, "R9 climb release");
    end
    strobe(1, 0, "R5 top clamp");
    strobe(0, 0, "R3 release at top");
    strobe(1, 1, "R4 both new, down wins");
    strobe(0, 1, "R3 down held up released");
    strobe(1, 1, "R4 up new while down held");
    strobe(0, 0, "R3 both released");

    // R7: button activity without a strobe changes nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      up_btn_n = i[0];
      dn_btn_n = ~i[0];
      chk(count_o == m_cnt, "R7 no strobe", count_o, m_cnt);
    end
    @(negedge clk);
    up_btn_n = 1;
    dn_btn_n = 1;

    // R2: press, then release and press again between strobes: not new
    strobe(1, 0, "R2 first press");
    @(negedge clk); up_btn_n = 1;
    @(negedge clk); up_btn_n = 0;
    strobe(1, 0, "R2 unseen release");
    strobe(0, 0, "R2 release");

    // descend to the bottom and clamp
    for (int i = 0; i < 100; i++) begin
      strobe(0, 1, "R4 descend");
      strobe(0, 0, "R3 descend release");
    end
    strobe(0, 1, "R5 bottom clamp");
    strobe(0, 0, "R5 release at bottom");
    strobe(1, 0, "R1 up again");
    strobe(1, 0, "R3 held again");

    // R8: reset with up held clears the stored state as well
    repeat (2) @(negedge clk);
    do_reset();
    chk_out("R8 mid reset", 0);
    strobe(1, 0, "R8 held press counts after reset");
    strobe(0, 0, "R8 release");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule